// File: doc/BRIEF.md
# Triggered converter sample feeder

This block is the digital side of a 12-bit converter on a simple register bus. Software writes samples into a 32-entry first-in first-out store. Each trigger takes the oldest sample and loads it into the converter output register. A trigger comes either from a command-register write or from a rising edge on an external pin. After an accepted trigger, a settling timer holds a busy indication for a number of bus clocks chosen by a 3-bit code. Four sticky flags record overflow, underflow, completed settling and rejected triggers. Software clears each flag by writing a one to its bit.

The settling timer is a two-state machine. In `ST_IDLE` the converter is ready. An accepted trigger with a non-zero settling time takes the transition IDLE-to-SETTLE and loads the down-counter. In `ST_SETTLE` the busy output is high. When the counter reaches zero, the transition SETTLE-to-IDLE fires and produces the completion pulse. A trigger with settling code 0 stays in `ST_IDLE` and gives the completion pulse at once.

Register map (word addresses on `bus_addr`): 0 configuration (bit0 enable, bits 3:1 settling code, readable); 1 command (bit0 manual trigger strobe, bit1 external-trigger enable, rewritten on every write, bit1 readable); 2 sample push (bits 11:0); 3 flush (bit0); 4 status (bits 5:0 entry count, bit8 busy); 5 flags (bit0 overflow, bit1 underflow, bit2 done, bit3 trigger error); 6 flag clear (write one to clear, same bit positions). Reads of any other address return 0.

Top module: `dac_feed_ctrl`

## Requirements
- R1: After reset the output code is 0, the entry count is 0, busy is low, all flags are 0 and the block is disabled.
- R2: A write to address 2 stores bits 11:0 of the write data as a sample, ignores bits 15:12, and increments the entry count in status bits 5:0.
- R3: A sample write while the count is 32 is dropped, the count stays 32, and flag bit0 (overflow) is set.
- R4: Writing 1 in bit0 to address 3 empties the store, so the count reads 0 afterwards.
- R5: An accepted trigger holds busy (status bit8 and `busy_o`) high for exactly 25 times the settling code clock cycles. Code 7 behaves as code 6 (150 cycles), and code 0 never raises busy.
- R6: Flag bit2 (done) is set in the cycle busy falls, or at the trigger itself when the code is 0.
- R7: A trigger while busy is high or while the enable bit is 0 leaves the output and the count unchanged and sets flag bit3 (trigger error).
- R8: A trigger on an enabled, idle block with an empty store leaves the output unchanged and sets flag bit1 (underflow).
- R9: With command bit1 set, a rising edge on `ext_trig_in` passes a two-flop synchronizer and acts as one trigger. The sample reaches the output on the third clock edge after the pin rises. With command bit1 clear, the pin is ignored.
- R10: Writing to address 6 clears exactly the flags whose bits are 1 in the write data. A flag being set in the same cycle wins over its clear.
- R11: An accepted trigger loads the oldest stored sample into `dac_code` at the clock edge that samples the trigger, in the order the samples were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| dac_code | output | 12 | Converter output register |
| busy_o | output | 1 | High while the converter is settling |

## Verification
A scoreboard queues each written sample. It checks the output whenever busy rises, and directly after triggers with code 0. This separates correct first-in order from a store that repeats or skips entries. Settling is timed with codes 1, 7 and 0, which tells a correct 25-cycle multiple and the clamp of code 7 apart from off-by-one counters. Triggers are tried while busy, while disabled, on an empty store and from the external pin with its enable on and off, and each case is checked against its own flag. A full store, an overflow write, a flush and a partial flag clear show the boundary counts and the write-one-to-clear behaviour.

// File: rtl/dac_feed_pkg.sv
package dac_feed_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLUSH = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FCLR  = 3'd6;

    localparam int FL_OVF  = 0;
    localparam int FL_UNF  = 1;
    localparam int FL_DONE = 2;
    localparam int FL_TERR = 3;
    localparam int NFLAGS  = 4;

    localparam int STAT_BUSY_BIT = 8;

    typedef enum logic {
        ST_IDLE,
        ST_SETTLE
    } settle_st_t;

endpackage

// File: rtl/dac_smp_fifo.sv
module dac_smp_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    input  logic            flush,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count,
    output logic            empty,
    output logic            full
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= wrap_inc(wptr);
            end
            if (pop_ok) begin
                rptr <= wrap_inc(rptr);
            end
            count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

    p_count_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));

    p_flush_empties_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    p_full_drop_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CNTW'(DEPTH)));

endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q && !last_q;

    p_rise_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/dac_settle_fsm.sv
module dac_settle_fsm
    import dac_feed_pkg::*;
#(
    parameter int STEP    = 25,
    parameter int MAXCODE = 6,
    localparam int MAXTICKS = STEP * MAXCODE,
    localparam int CW       = $clog2(MAXTICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] code,
    output logic       busy,
    output logic       done_pulse
);

    settle_st_t    state_q;
    settle_st_t    state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [2:0]    eff_code;
    logic [CW-1:0] ticks;

    assign eff_code = (code > 3'(MAXCODE)) ? 3'(MAXCODE) : code;
    assign ticks    = CW'(eff_code) * CW'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (ticks == '0) begin
                        done_pulse = 1'b1;
                    end else begin
                        state_d = ST_SETTLE;
                        cnt_d   = ticks - 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d    = ST_IDLE;
                    done_pulse = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_SETTLE);

    p_settle_exit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cnt_q == '0) |=> !busy);

    p_cnt_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXTICKS));

    p_no_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> busy);

endmodule

// File: rtl/dac_feed_ctrl.sv
module dac_feed_ctrl
    import dac_feed_pkg::*;
#(
    parameter int DW      = 12,
    parameter int DEPTH   = 32,
    parameter int BW      = 16,
    parameter int STEP    = 25,
    parameter int MAXCODE = 6,
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic              ext_trig_in,
    output logic [DW-1:0]     dac_code,
    output logic              busy_o
);

    logic              cfg_en;
    logic [2:0]        cfg_code;
    logic              ext_en;
    logic [NFLAGS-1:0] flags;

    logic              wr_cfg, wr_cmd, wr_smp, wr_flush, wr_fclr;
    logic              man_trig, ext_rise, trig;
    logic              accept, terr_ev, unf_ev, ovf_ev, done_ev;
    logic [DW-1:0]     head;
    logic [CNTW-1:0]   count;
    logic              empty, full;
    logic [NFLAGS-1:0] set_vec, clr_vec;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[BW-1:DW];

    assign wr_cfg   = bus_we && (bus_addr == A_CFG);
    assign wr_cmd   = bus_we && (bus_addr == A_CMD);
    assign wr_smp   = bus_we && (bus_addr == A_SMP);
    assign wr_flush = bus_we && (bus_addr == A_FLUSH) && bus_wdata[0];
    assign wr_fclr  = bus_we && (bus_addr == A_FCLR);

    assign man_trig = wr_cmd && bus_wdata[0];
    assign trig     = man_trig || (ext_en && ext_rise);
    assign accept   = trig && cfg_en && !busy_o && !empty;
    assign terr_ev  = trig && (!cfg_en || busy_o);
    assign unf_ev   = trig && cfg_en && !busy_o && empty;
    assign ovf_ev   = wr_smp && full;

    dac_smp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_smp),
        .push_data (bus_wdata[DW-1:0]),
        .pop       (accept),
        .flush     (wr_flush),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .full      (full)
    );

    dac_trig_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig_in),
        .rise     (ext_rise)
    );

    dac_settle_fsm #(.STEP(STEP), .MAXCODE(MAXCODE)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .code       (cfg_code),
        .busy       (busy_o),
        .done_pulse (done_ev)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_code <= '0;
            ext_en   <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_en   <= bus_wdata[0];
                cfg_code <= bus_wdata[3:1];
            end
            if (wr_cmd) begin
                ext_en <= bus_wdata[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
        end else if (accept) begin
            dac_code <= head;
        end
    end

    always_comb begin
        set_vec          = '0;
        set_vec[FL_OVF]  = ovf_ev;
        set_vec[FL_UNF]  = unf_ev;
        set_vec[FL_DONE] = done_ev;
        set_vec[FL_TERR] = terr_ev;
        clr_vec          = wr_fclr ? bus_wdata[NFLAGS-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG:  bus_rdata[3:0] = {cfg_code, cfg_en};
            A_CMD:  bus_rdata[1]   = ext_en;
            A_STAT: begin
                bus_rdata[CNTW-1:0]     = count;
                bus_rdata[STAT_BUSY_BIT] = busy_o;
            end
            A_FLAG: bus_rdata[NFLAGS-1:0] = flags;
            default: bus_rdata = '0;
        endcase
    end

    p_pop_order_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (dac_code == $past(head)));

    p_trig_reject_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy_o) |=> (flags[FL_TERR] && $stable(dac_code)));

    p_underflow_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (trig && cfg_en && !busy_o && empty) |=> (flags[FL_UNF] && $stable(dac_code)));

    p_done_on_fall_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> flags[FL_DONE]);

    p_overflow_flag_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_smp && full) |=> flags[FL_OVF]);

endmodule

// File: tb/test_dac_feed_ctrl.sv
module test_dac_feed_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig_in = 1'b0;
    logic [11:0] dac_code;
    logic        busy_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [11:0] exp_q[$];
    logic busy_prev = 1'b0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    dac_feed_ctrl i_dac_feed_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_trig_in (ext_trig_in),
        .dac_code    (dac_code),
        .busy_o      (busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every rise of busy marks a pop; compare with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && mon_on && busy_o && !busy_prev) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected pop", 1, 0);
            end else begin
                check("R11 pop order", int'(dac_code), int'(exp_q.pop_front()));
            end
        end
        busy_prev <= busy_o;
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push_sample(input logic [15:0] v);
        bus_write(3'd2, v);
        exp_q.push_back(v[11:0]);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        check("watchdog", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        logic [11:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 dac_code", int'(dac_code), 0);
        check("R1 busy", int'(busy_o), 0);
        bus_read(3'd4, rd); check("R1 status", int'(rd), 0);
        bus_read(3'd5, rd); check("R1 flags", int'(rd), 0);
        bus_read(3'd0, rd); check("R1 cfg", int'(rd), 0);

        // R2 pushes, upper bits dropped
        mon_on = 1'b1;
        bus_write(3'd0, 16'h0003);          // enable, code 1
        push_sample(16'h0123);
        push_sample(16'h0ABC);
        push_sample(16'hFFFF);
        bus_read(3'd4, rd); check("R2 count", int'(rd), 3);

        // R5/R11 code 1: 25 cycles
        bus_write(3'd1, 16'h0001);
        measure_busy(n); check("R5 code1 busy cycles", n, 25);
        bus_read(3'd5, rd); check("R6 done flag", int'(rd), 4);

        // R7 trigger while busy
        bus_write(3'd1, 16'h0001);
        bus_write(3'd1, 16'h0001);
        measure_busy(n);
        check("R7 output held", int'(dac_code), 12'hABC);
        bus_read(3'd4, rd); check("R7 count after busy trigger", int'(rd), 1);
        bus_read(3'd5, rd); check("R7 terr flag", int'(rd[3]), 1);

        // R10 partial clear
        bus_write(3'd6, 16'h0004);
        bus_read(3'd5, rd); check("R10 partial clear", int'(rd), 8);
        bus_write(3'd6, 16'h000F);
        bus_read(3'd5, rd); check("R10 full clear", int'(rd), 0);

        // R5 code 7 clamps to 150
        bus_write(3'd0, 16'h000F);
        bus_write(3'd1, 16'h0001);
        measure_busy(n); check("R5 code7 busy cycles", n, 150);
        check("R2 max value", int'(dac_code), 12'hFFF);

        // R5/R6 code 0
        bus_write(3'd0, 16'h0001);
        bus_write(3'd6, 16'h000F);
        push_sample(16'h0055);
        bus_write(3'd1, 16'h0001);
        check("R5 code0 no busy", int'(busy_o), 0);
        e = exp_q.pop_front();
        check("R11 code0 output", int'(dac_code), int'(e));
        bus_read(3'd5, rd); check("R6 done code0", int'(rd), 4);

        // R3 fill and overflow
        bus_write(3'd6, 16'h000F);
        for (int i = 0; i < 32; i++) push_sample(16'(i * 3 + 7));
        bus_read(3'd4, rd); check("R3 count full", int'(rd), 32);
        bus_read(3'd5, rd); check("R3 no flag at 32", int'(rd), 0);
        bus_write(3'd2, 16'h0777);
        bus_read(3'd4, rd); check("R3 count stays", int'(rd), 32);
        bus_read(3'd5, rd); check("R3 overflow flag", int'(rd), 1);

        // R11 order with code 0
        for (int i = 0; i < 2; i++) begin
            bus_write(3'd1, 16'h0001);
            e = exp_q.pop_front();
            check("R11 order", int'(dac_code), int'(e));
        end

        // R4 flush, R8 underflow
        bus_write(3'd3, 16'h0001);
        exp_q.delete();
        bus_read(3'd4, rd); check("R4 flush count", int'(rd), 0);
        bus_write(3'd6, 16'h000F);
        e = dac_code;
        bus_write(3'd1, 16'h0001);
        check("R8 output unchanged", int'(dac_code), int'(e));
        bus_read(3'd5, rd); check("R8 underflow flag", int'(rd), 2);

        // R7 disabled
        bus_write(3'd6, 16'h000F);
        bus_write(3'd0, 16'h0000);
        push_sample(16'h0321);
        bus_write(3'd1, 16'h0001);
        check("R7 disabled output", int'(dac_code), int'(e));
        bus_read(3'd4, rd); check("R7 disabled count", int'(rd), 1);
        bus_read(3'd5, rd); check("R7 disabled terr", int'(rd), 8);

        // R9 external trigger
        bus_write(3'd0, 16'h0001);
        bus_write(3'd1, 16'h0002);
        @(negedge clk); ext_trig_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 not yet", int'(dac_code), int'(e));
        @(negedge clk);
        check("R9 ext pop", int'(dac_code), 12'h321);
        void'(exp_q.pop_front());
        repeat (4) @(negedge clk);
        ext_trig_in = 1'b0;
        bus_read(3'd4, rd); check("R9 single pop", int'(rd), 0);
        bus_write(3'd1, 16'h0000);
        push_sample(16'h0444);
        @(negedge clk); ext_trig_in = 1'b1;
        repeat (5) @(negedge clk);
        ext_trig_in = 1'b0;
        check("R9 disabled pin", int'(dac_code), 12'h321);
        bus_read(3'd4, rd); check("R9 disabled count", int'(rd), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule